// File: doc/BRIEF.md
# Flag-Gated Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port driven from a register-style interface. Software writes a byte into the transmit buffer to send a frame. Software reads received bytes from the receive buffer. Two sticky flags report events: one marks that a transmission reached its stop bit, and one marks that a byte was received. Each flag is cleared only by a software clear strobe. A single interrupt request is the OR of both flags, gated by an interrupt enable.

A frame holds one low start bit, eight data bits sent least significant bit first, and one high stop bit. The transmitter and the receiver each count their own 16x oversampling tick input. A tick is a one-cycle enable pulse; sixteen ticks make one bit time.

The receiver has a gate on what it keeps. A finished byte is committed only while the receive flag is clear. If stop checking is enabled, the byte is also committed only when the sampled stop bit is 1. A committed frame's stop bit is kept in a separate status output.

**Transmitter states and transitions:**
- `TX_IDLE` goes to `TX_START` on a buffer write.
- `TX_START` goes to `TX_DATA` after 16 ticks.
- `TX_DATA` goes to `TX_STOP` after the eighth bit.
- `TX_STOP` goes to `TX_IDLE` after 16 ticks.

**Receiver states and transitions:**
- `RX_IDLE` goes to `RX_START` on a tick that sees the line low while receive is enabled.
- `RX_START` goes back to `RX_IDLE` if the line is high at the mid-bit sample, or goes to `RX_DATA` after 16 ticks.
- `RX_DATA` goes to `RX_STOP` after the eighth bit.
- `RX_STOP` goes to `RX_IDLE` right after the third stop-bit sample.

Top module: `ser_xcvr`

## Requirements
- R1: The transmit line idles at 1. A frame is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. Each bit lasts 16 transmit ticks.
- R2: A transmit buffer write while idle starts a frame. A write while a frame is in progress is ignored: the current frame's bits are unchanged and no second frame follows.
- R3: The transmit flag rises at the start of the stop bit. It is still 0 during data bit 7 and is 1 during the stop bit.
- R4: A start bit is detected only while the receive enable input is 1. A frame sent while it is 0 sets no flag and leaves the buffer unchanged.
- R5: Each received data bit is the majority of three line samples taken at ticks 7, 8 and 9 of the bit. A one-sample glitch does not change the byte.
- R6: A low pulse that is gone by the mid-bit sample of the start bit is rejected. The receiver returns to idle and loads nothing.
- R7: A byte is loaded only while the receive flag is 0. If the flag is 1, the buffer, the stop status and the flag all stay unchanged.
- R8: When the stop-check input is 1, a frame with a 0 stop bit is not loaded. When stop-check is 0, such a frame is loaded and the stop status reads 0. A loaded frame sets the stop status to its stop bit and sets the receive flag.
- R9: Both flags stay set until their clear strobe is asserted. Hardware never clears them.
- R10: The interrupt request equals the interrupt enable ANDed with the OR of the two flags.
- R11: After reset, the transmit line is 1, both flags, the interrupt request, the receive buffer and the stop status are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_tick | input | 1 | Transmit 16x oversampling enable pulse |
| rx_tick | input | 1 | Receive 16x oversampling enable pulse |
| txbuf_wr | input | 1 | Transmit buffer write strobe |
| txbuf_wdata | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| stop_chk | input | 1 | Require stop bit = 1 for a load |
| irq_en | input | 1 | Interrupt enable |
| tx_flag_clr | input | 1 | Clears the transmit flag |
| rx_flag_clr | input | 1 | Clears the receive flag |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rxbuf_rdata | output | 8 | Receive buffer |
| rx_stop | output | 1 | Stop bit of the last loaded frame |
| tx_flag | output | 1 | Transmit-done flag |
| rx_flag | output | 1 | Receive-done flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench times the transmit flag against bit 7 and the stop bit. A design that raised the flag at the end of the frame would miss the stop-bit sample.

It writes the transmit buffer in the middle of a frame. A design that reloaded its shifter there would corrupt the bits that follow or send a second frame.

On the receive side it covers several cases, and each would show up at the ports if handled wrong:
- **Flag set:** frames arrive while the receive flag is still set. A design that overwrote the buffer would show the new byte.
- **Bad stop bit:** frames carry a 0 stop bit with stop checking both on and off. Wrong gating would load or drop the wrong frames.
- **Single-sample glitches:** a glitch hits mid-bit. A design that sampled only once would flip that bit.
- **Short low pulse:** a brief low pulse reaches the line. A design without start confirmation would load a garbage byte.

// File: rtl/ser_xcvr_pkg.sv
package ser_xcvr_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/ser_xcvr_tx.sv
module ser_xcvr_tx
    import ser_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int CW = $clog2(OSR);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         st_q, st_d;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              done_q;
    logic              bit_end;

    assign bit_end = tick && (cnt_q == CW'(OSR - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (load) st_d = TX_START;
            TX_START: if (bit_end) st_d = TX_DATA;
            TX_DATA:  if (bit_end && idx_q == IW'(DATA_W - 1)) st_d = TX_STOP;
            TX_STOP:  if (bit_end) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (st_q == TX_DATA) && (st_d == TX_STOP);
            if (st_q == TX_IDLE) begin
                cnt_q <= '0;
                idx_q <= '0;
                if (load) sh_q <= load_data;
            end else if (tick) begin
                cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
                if (bit_end && st_q == TX_DATA) begin
                    sh_q  <= sh_q >> 1;
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy = (st_q != TX_IDLE);
        done = done_q;
        unique case (st_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            default:  txd = 1'b1;
        endcase
    end

    assert_busy_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != TX_IDLE && load && !tick) |=> $stable(sh_q));

    assert_done_in_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (st_q == TX_STOP));

endmodule

// File: rtl/ser_xcvr_rx.sv
module ser_xcvr_rx
    import ser_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              line,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              stop_bit
);
    localparam int CW    = $clog2(OSR);
    localparam int IW    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int MID   = OSR / 2;
    localparam int EARLY = MID - 1;
    localparam int LATE  = MID + 1;

    rx_state_e         st_q, st_d;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] sh_q;
    logic [1:0]        vote_q;
    logic              stop_q;
    logic              done_q;
    logic              bit_end;
    logic              maj;

    assign bit_end = tick && (cnt_q == CW'(OSR - 1));
    assign maj     = vote3(vote_q[0], vote_q[1], line);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:  if (tick && enable && !line) st_d = RX_START;
            RX_START: begin
                if (tick && cnt_q == CW'(MID) && line) st_d = RX_IDLE;
                else if (bit_end)                     st_d = RX_DATA;
            end
            RX_DATA:  if (bit_end && idx_q == IW'(DATA_W - 1)) st_d = RX_STOP;
            RX_STOP:  if (tick && cnt_q == CW'(LATE)) st_d = RX_IDLE;
            default:  st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            vote_q <= '0;
            stop_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st_q == RX_IDLE) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else if (tick) begin
                cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
                if (cnt_q == CW'(EARLY)) vote_q[0] <= line;
                if (cnt_q == CW'(MID))   vote_q[1] <= line;
                if (cnt_q == CW'(LATE)) begin
                    if (st_q == RX_DATA) sh_q <= {maj, sh_q[DATA_W-1:1]};
                    if (st_q == RX_STOP) begin
                        stop_q <= maj;
                        done_q <= 1'b1;
                    end
                end
                if (bit_end && st_q == RX_DATA) idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        done     = done_q;
        data     = sh_q;
        stop_bit = stop_q;
    end

    assert_no_start_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_IDLE && !enable) |=> (st_q == RX_IDLE));

    assert_done_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(st_q) == RX_STOP));

endmodule

// File: rtl/ser_xcvr.sv
module ser_xcvr
    import ser_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_tick,
    input  logic              rx_tick,
    input  logic              txbuf_wr,
    input  logic [DATA_W-1:0] txbuf_wdata,
    input  logic              rx_en,
    input  logic              stop_chk,
    input  logic              irq_en,
    input  logic              tx_flag_clr,
    input  logic              rx_flag_clr,
    input  logic              rxd,
    output logic              txd,
    output logic [DATA_W-1:0] rxbuf_rdata,
    output logic              rx_stop,
    output logic              tx_flag,
    output logic              rx_flag,
    output logic              irq
);
    logic [SYNC_N-1:0] sync_q;
    logic              tx_busy, tx_done;
    logic              rx_done, rx_stop_raw;
    logic [DATA_W-1:0] rx_byte;
    logic              commit;
    logic              tx_flag_q, rx_flag_q, stop_q;
    logic [DATA_W-1:0] rxbuf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_N-2:0], rxd};
    end

    ser_xcvr_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tx_tick), .load(txbuf_wr),
        .load_data(txbuf_wdata), .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    ser_xcvr_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(rx_tick), .enable(rx_en),
        .line(sync_q[SYNC_N-1]), .done(rx_done), .data(rx_byte),
        .stop_bit(rx_stop_raw)
    );

    assign commit = rx_done && !rx_flag_q && (!stop_chk || rx_stop_raw);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_flag_q <= 1'b0;
            rx_flag_q <= 1'b0;
            stop_q    <= 1'b0;
            rxbuf_q   <= '0;
        end else begin
            if (tx_done)          tx_flag_q <= 1'b1;
            else if (tx_flag_clr) tx_flag_q <= 1'b0;
            if (commit) begin
                rx_flag_q <= 1'b1;
                rxbuf_q   <= rx_byte;
                stop_q    <= rx_stop_raw;
            end else if (rx_flag_clr) begin
                rx_flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        tx_flag     = tx_flag_q;
        rx_flag     = rx_flag_q;
        rx_stop     = stop_q;
        rxbuf_rdata = rxbuf_q;
        irq         = irq_en && (tx_flag_q || rx_flag_q);
    end

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag_q && !rx_flag_clr) |=> rx_flag_q);

    assert_buf_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag_q |=> ($stable(rxbuf_q) && $stable(stop_q)));

    assert_stop_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && stop_chk && !rx_stop_raw && !rx_flag_q) |=> !rx_flag_q);

    assert_txflag_in_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag_q) |-> tx_busy);

endmodule

// File: tb/ser_xcvr_tb_top.sv
`timescale 1ns/1ps
module ser_xcvr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    int unsigned tdiv = 0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic       rx_en = 1'b1, stop_chk = 1'b0, irq_en = 1'b0;
    logic       tclr = 1'b0, rclr = 1'b0, rxd = 1'b1;
    logic       txd, rx_stop, tx_flag, rx_flag, irq;
    logic [7:0] rdata;

    int nvec = 0, nfail = 0;
    logic [7:0] exp_data = '0;
    logic       exp_stop = 1'b0, exp_flag = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tdiv <= tdiv + 1;
        tick <= tdiv[0];
    end

    ser_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .tx_tick(tick), .rx_tick(tick),
        .txbuf_wr(wr), .txbuf_wdata(wdata), .rx_en(rx_en), .stop_chk(stop_chk),
        .irq_en(irq_en), .tx_flag_clr(tclr), .rx_flag_clr(rclr), .rxd(rxd),
        .txd(txd), .rxbuf_rdata(rdata), .rx_stop(rx_stop), .tx_flag(tx_flag),
        .rx_flag(rx_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tclr();
        tclr = 1'b1; cyc(1); tclr = 1'b0;
    endtask

    task automatic pulse_rclr();
        rclr = 1'b1; cyc(1); rclr = 1'b0;
        exp_flag = 1'b0;
    endtask

    // Sends one byte and checks the line at each mid-bit (R1, R2, R3)
    task automatic tx_frame(input logic [7:0] b, input bit inject);
        int gap;
        pulse_tclr();
        wr = 1'b1; wdata = b; cyc(1); wr = 1'b0;
        cyc(15);
        chk("R1 start bit", txd, 0);
        gap = 32;
        for (int i = 0; i < 8; i++) begin
            cyc(gap);
            gap = 32;
            chk("R1 data bit", txd, b[i]);
            if (i == 7) chk("R3 flag low in bit 7", tx_flag, 0);
            if (inject && i == 2) begin
                wr = 1'b1; wdata = ~b; cyc(1); wr = 1'b0;
                gap = 31;
            end
        end
        cyc(32);
        chk("R1 stop bit", txd, 1);
        chk("R3 flag in stop bit", tx_flag, 1);
        cyc(32);
        if (inject) begin
            for (int k = 0; k < 4; k++) begin
                cyc(16);
                chk("R2 no second frame", txd, 1);
            end
        end
    endtask

    // Drives one frame on rxd; glitch_bit >= 0 inverts one sample window
    task automatic rx_send(input logic [7:0] b, input logic stopv, input int glitch_bit);
        rxd = 1'b0; cyc(32);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            if (i == glitch_bit) begin
                cyc(16); rxd = ~b[i]; cyc(2); rxd = b[i]; cyc(14);
            end else begin
                cyc(32);
            end
        end
        rxd = stopv; cyc(32);
        rxd = 1'b1; cyc(48);
    endtask

    function automatic bit accept(input logic en, input logic flag,
                                  input logic schk, input logic stopv);
        return en && !flag && (!schk || stopv);
    endfunction

    task automatic rx_case(input string req, input logic [7:0] b, input logic stopv,
                           input int glitch_bit);
        rx_send(b, stopv, glitch_bit);
        if (accept(rx_en, exp_flag, stop_chk, stopv)) begin
            exp_data = b; exp_stop = stopv; exp_flag = 1'b1;
        end
        chk(req, rx_flag, exp_flag);
        chk(req, rdata, exp_data);
        chk(req, rx_stop, exp_stop);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        logic       sv;
        void'($urandom(32'h1f2e3d4c));
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        chk("R11 txd idle", txd, 1);
        chk("R11 tx flag", tx_flag, 0);
        chk("R11 rx flag", rx_flag, 0);
        chk("R11 irq", irq, 0);
        chk("R11 rx buffer", rdata, 0);
        chk("R11 stop status", rx_stop, 0);

        // Transmit: directed then random
        tx_frame(8'h00, 1'b0);
        tx_frame(8'hFF, 1'b0);
        tx_frame(8'hA5, 1'b1);
        for (int n = 0; n < 6; n++) tx_frame(8'($urandom), 1'b0);

        // R9 transmit flag holds; R10 interrupt
        cyc(100);
        chk("R9 tx flag holds", tx_flag, 1);
        irq_en = 1'b0; cyc(1);
        chk("R10 irq masked", irq, 0);
        irq_en = 1'b1; cyc(1);
        chk("R10 irq from tx flag", irq, 1);
        pulse_tclr();
        chk("R9 tx flag cleared", tx_flag, 0);
        chk("R10 irq no flags", irq, 0);

        // R4 receive disabled
        rx_en = 1'b0;
        rx_case("R4 disabled", 8'h3C, 1'b1, -1);
        rx_en = 1'b1;

        // R6 false start then a good frame
        rxd = 1'b0; cyc(6); rxd = 1'b1; cyc(80);
        chk("R6 false start no flag", rx_flag, 0);
        rx_case("R6 good frame after false start", 8'h81, 1'b1, -1);
        chk("R10 irq from rx flag", irq, 1);
        cyc(300);
        chk("R9 rx flag holds", rx_flag, 1);
        pulse_rclr();

        // R5 glitches in several bits
        rx_case("R5 glitch bit 0", 8'h5A, 1'b1, 0);
        pulse_rclr();
        rx_case("R5 glitch bit 7", 8'hC3, 1'b1, 7);
        pulse_rclr();

        // R7 overrun: flag left set
        rx_case("R7 flag set blocks load", 8'h11, 1'b1, -1);
        rx_case("R7 flag set blocks load", 8'h22, 1'b1, -1);
        pulse_rclr();

        // R8 stop checking
        stop_chk = 1'b1;
        rx_case("R8 bad stop rejected", 8'h77, 1'b0, -1);
        stop_chk = 1'b0;
        rx_case("R8 bad stop accepted", 8'h66, 1'b0, -1);
        pulse_rclr();

        // Random receive mix (R7, R8)
        for (int n = 0; n < 16; n++) begin
            rb = 8'($urandom);
            sv = ($urandom % 4) != 0;
            stop_chk = $urandom % 2;
            if (($urandom % 3) != 0) pulse_rclr();
            rx_case("R8 random frame", rb, sv, ($urandom % 2) ? int'($urandom % 8) : -1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule